// File: doc/BRIEF.md
# Framed Four-Bit Pattern Detector

This block watches a serial stream of single bits and cuts it into consecutive four-bit frames. The frames do not overlap. The output `z` is raised only on the last bit of a frame, and only if that frame, read in arrival order, is one of two targets: `0101` or `1001`. Once a frame's fourth bit has been taken, the machine goes back to its start state, whatever the frame held. The next accepted bit therefore always opens a fresh frame.

A bit is consumed only in a cycle where `din_valid` is high. Idle cycles leave the frame position and the partial prefix alone. `z` is a Mealy output: it is true in the same cycle in which the completing bit is presented, before the clock edge that consumes it.

The two targets share the suffix `01`. Because of this, the prefixes `01` and `10` reach a common state after two bits. The prefixes `00` and `11` fall into one reject path that only counts out the rest of the frame. With equivalent states merged, the machine has seven states held in three flip-flops.

Top module: `quad_frame_detector`

## Requirements
- R1: While `srst` is high at a rising edge, the machine returns to its start state. `z` is 0 in every cycle in which `srst` is high. The first valid bit after reset is bit one of a frame.
- R2: `z` is 1 in the cycle where a valid fourth bit completes the frame `0101`. The first-arriving bit is the leftmost digit.
- R3: `z` is 1 in the cycle where a valid fourth bit completes the frame `1001`. The first-arriving bit is the leftmost digit.
- R4: `z` is 0 for the other fourteen four-bit frames. It is also 0 while the first, second or third bit of any frame is presented.
- R5: Frames are back to back and never overlap. After the fourth valid bit, the next valid bit starts a new frame, whatever the previous frame contained.
- R6: In a cycle with `din_valid` low, `z` is 0 and the frame position and prefix are kept unchanged, whatever the value on `din`.
- R7: `z` depends combinationally on the current `din` and `din_valid`. It appears in the same cycle the completing bit is driven, with no added cycle of delay.
- R8: Asserting `srst` part-way through a frame discards the partial prefix. The bits that follow are framed from bit one again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| srst | input | 1 | Synchronous reset, active high |
| din_valid | input | 1 | High when `din` carries a bit to consume |
| din | input | 1 | Serial data bit |
| z | output | 1 | High on the last bit of a matching frame |

## Verification
The bench checks all sixteen frames one after another. It also runs a long random stream with random idle gaps against a four-bit shift-register model. A design that matched a sliding window would fire across a frame boundary. A design that ignored `din_valid` would take idle `din` values into the frame, so the frame alignment would shift. Directed cases cover three more faults. A lazy reset would match a stale prefix after a reset in mid-frame. A registered `z` would show the match one cycle late. A merged state that is not truly equivalent, such as treating the prefixes `0` and `1` as one state, would accept a frame like `0001` or `1101`.

// File: rtl/quad_frame_detector.sv
module quad_frame_detector (
  input  logic clk,
  input  logic srst,
  input  logic din_valid,
  input  logic din,
  output logic z
);

  localparam logic [2:0] ST_START = 3'd0;
  localparam logic [2:0] ST_LEAD0 = 3'd1;
  localparam logic [2:0] ST_LEAD1 = 3'd2;
  localparam logic [2:0] ST_PAIR  = 3'd3;
  localparam logic [2:0] ST_DUD2  = 3'd4;
  localparam logic [2:0] ST_TRIO  = 3'd5;
  localparam logic [2:0] ST_DUD3  = 3'd6;

  logic [2:0] state, state_nx;

  always_comb begin
    state_nx = state;
    if (din_valid) begin
      case (state)
        ST_START: state_nx = din ? ST_LEAD1 : ST_LEAD0;
        ST_LEAD0: state_nx = din ? ST_PAIR  : ST_DUD2;
        ST_LEAD1: state_nx = din ? ST_DUD2  : ST_PAIR;
        ST_PAIR:  state_nx = din ? ST_DUD3  : ST_TRIO;
        ST_DUD2:  state_nx = ST_DUD3;
        ST_TRIO:  state_nx = ST_START;
        ST_DUD3:  state_nx = ST_START;
        default:  state_nx = ST_START;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (srst) state <= ST_START;
    else      state <= state_nx;
  end

  assign z = !srst && din_valid && din && (state == ST_TRIO);

endmodule

// File: rtl/quad_frame_detector_checks.sv
module quad_frame_detector_checks (
  input logic       clk,
  input logic       srst,
  input logic       din_valid,
  input logic       din,
  input logic       z,
  input logic [2:0] state
);

  logic [1:0] pos;

  always_ff @(posedge clk) begin
    if (srst)           pos <= 2'd0;
    else if (din_valid) pos <= pos + 2'd1;
  end

  a_r6_no_z_when_idle: assert property (@(posedge clk) disable iff (srst)
    !din_valid |-> !z);

  a_r6_state_held: assert property (@(posedge clk) disable iff (srst)
    !din_valid |=> $stable(state));

  a_r4_z_only_on_fourth: assert property (@(posedge clk) disable iff (srst)
    z |-> (pos == 2'd3));

  a_r2_z_needs_one: assert property (@(posedge clk) disable iff (srst)
    z |-> din);

  a_r5_frame_restart: assert property (@(posedge clk) disable iff (srst)
    (din_valid && pos == 2'd3) |=> (state == 3'd0));

  a_r1_state_legal: assert property (@(posedge clk) disable iff (srst)
    state != 3'd7);

endmodule

bind quad_frame_detector quad_frame_detector_checks u_checks (
  .clk(clk), .srst(srst), .din_valid(din_valid), .din(din), .z(z), .state(state)
);

// File: tb/quad_frame_detector_test.sv
`timescale 1ns/1ps
module quad_frame_detector_test;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic din_valid = 1'b0;
  logic din = 1'b0;
  logic z;

  int checks = 0;
  int fails  = 0;
  logic [2:0] hist = 3'd0;
  int cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  quad_frame_detector uut (
    .clk(clk), .srst(srst), .din_valid(din_valid), .din(din), .z(z)
  );

  function automatic logic exp_z(input int c, input logic [2:0] h, input logic v, input logic b);
    logic [3:0] fr;
    fr = {h, b};
    return v && (c == 3) && (fr == 4'b0101 || fr == 4'b1001);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: z=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic b, input string req);
    @(negedge clk);
    din_valid = v;
    din = b;
    #1;
    check(req, z, exp_z(cnt, hist, v, b));
    @(posedge clk);
    if (v) begin
      hist = {hist[1:0], b};
      cnt = (cnt == 3) ? 0 : cnt + 1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    srst = 1'b1;
    din_valid = 1'b1;
    din = 1'b1;
    #1;
    check("R1", z, 1'b0);
    @(posedge clk);
    @(negedge clk);
    srst = 1'b0;
    din_valid = 1'b0;
    cnt = 0;
    hist = 3'd0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    do_reset();

    // R2 R3 R4: every frame, back to back (R5)
    for (int f = 0; f < 16; f++) begin
      for (int i = 3; i >= 0; i--) step(1'b1, f[i], "R4");
    end

    // R2 directed, with an idle gap carrying din=1 (R6)
    step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b1, "R2");
    step(1'b0, 1'b1, "R6");
    step(1'b0, 1'b0, "R6");
    step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b1, "R7");

    // R3 directed
    step(1'b1, 1'b1, "R3");
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b1, "R3");

    // R5: stream 0 1 0 1 0 1 0 1 -> two matches, none straddling
    for (int i = 0; i < 8; i++) step(1'b1, i[0], "R5");
    // misaligned sliding match must not fire: 1 0 1 0 | 0 1 0 0
    step(1'b1, 1'b1, "R5"); step(1'b1, 1'b0, "R5");
    step(1'b1, 1'b1, "R5"); step(1'b1, 1'b0, "R5");
    step(1'b1, 1'b0, "R5"); step(1'b1, 1'b1, "R5");
    step(1'b1, 1'b0, "R5"); step(1'b1, 1'b0, "R5");

    // R8: reset after 010, then 0101 framed from scratch
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, "R8");
    step(1'b1, 1'b0, "R8");
    do_reset();
    step(1'b1, 1'b1, "R8");
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, "R8");
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, "R8");
    step(1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, "R8");

    // random stream with idle gaps
    for (int i = 0; i < 4000; i++) begin
      logic v;
      v = ($urandom_range(0, 3) != 0);
      step(v, 1'($urandom_range(0, 1)), v ? "R4" : "R6");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule